// File: doc/BRIEF.md
# Byte-Wide Read-Only Memory Port with Identification Mode

This block is the device-side control of a byte-wide read-only memory. It looks at an active-low chip select, an active-low output gate and a high-voltage identification flag. From these it decides three things: whether the data bus is driven, which byte goes onto it, and whether the part reports itself as active or in standby. Its outputs are a data byte and an enable for an external tri-state buffer. The data byte and the enable are registered, so both appear one clock after the inputs that select them.

The storage is an internal register array. At reset, or after a bulk erase, every bit in it reads as one. A preload port can only clear bits: each write ANDs the new byte into the stored word. When the identification flag is raised while the part is selected, the array is bypassed. Address bit 0 then chooses between a manufacturer byte and a device byte. Each of these is a 7-bit parameter payload, and hardware computes bit 7 so that the full byte has an odd number of ones. If any address bit above bit 0 is high in this mode, an invalid-access flag is raised.

Top module: `prom_port`

## Requirements
- R1: After reset, every stored byte reads 0xFF, `dq_oe` is 0, `dq_o` is 0x00, `pwr_standby` is 1 and `id_bad` is 0.
- R2: A one-cycle pulse on `erase_all` returns every stored byte to 0xFF.
- R3: A preload write (`prog_en`=1) stores the AND of the old byte at `addr` and `prog_data`, so it can clear bits but never set them.
- R4: `dq_oe` is 1 only in the cycle after both `ce_n` and `oe_n` were sampled low. Whenever `dq_oe` is 0, `dq_o` is 0x00.
- R5: While `ce_n` is high, the next cycle shows `pwr_standby`=1 and `dq_oe`=0, whatever `oe_n` and `hv_id` are doing.
- R6: With `ce_n` low and `oe_n` high, the part reports active (`pwr_standby`=0) but the bus is not driven.
- R7: With `ce_n`, `oe_n` and `hv_id` all low, `dq_o` shows the stored byte at `addr` one clock later.
- R8: With `hv_id` high, `ce_n` low and `oe_n` low, `dq_o` shows the manufacturer byte when `addr[0]`=0 and the device byte when `addr[0]`=1. Each byte is {parity, payload}, where bit 7 makes the number of ones in the 8-bit byte odd.
- R9: `id_bad` is 1 one cycle after `hv_id` is high with `ce_n` low and any of `addr[ADDR_W-1:1]` high; otherwise it is 0. The ID byte is still returned in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip select; high means standby |
| oe_n | input | 1 | Active-low output gate |
| hv_id | input | 1 | High-voltage identification flag |
| addr | input | ADDR_W | Byte address (read and preload) |
| prog_en | input | 1 | Preload write strobe |
| prog_data | input | 8 | Preload byte, ANDed into the stored word |
| erase_all | input | 1 | Bulk erase to all ones |
| dq_o | output | 8 | Registered output byte |
| dq_oe | output | 1 | Tri-state buffer enable |
| pwr_standby | output | 1 | 1 when the part is in standby |
| id_bad | output | 1 | Invalid address during identification mode |

## Verification
The hardest state to reach from the ports is a word in which bits have been cleared selectively and then cleared again. This is the only state in which the AND behaviour of the preload differs from a plain overwrite. The bench writes two overlapping patterns to one address and reads back their intersection. It then erases and reads the same address again. For identification mode, the bench keeps `hv_id` high and walks `addr` through four patterns: both values of bit 0 with the upper bits clear, and both with upper bits set. This exposes the parity bit, the byte selection and the invalid-access flag independently of each other.

// File: rtl/prom_port_pkg.sv
package prom_port_pkg;
  localparam int BYTE_W = 8;
  localparam int PAY_W  = BYTE_W - 1;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ARRAY = 2'd1,
    SRC_ID    = 2'd2
  } src_e;

  function automatic logic [BYTE_W-1:0] odd_byte(input logic [PAY_W-1:0] pay);
    return {~(^pay), pay};
  endfunction
endpackage

// File: rtl/prom_rst_sync.sv
module prom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/prom_id_gen.sv
module prom_id_gen
  import prom_port_pkg::*;
#(
  parameter logic [PAY_W-1:0] MFR_PAY = 7'h01,
  parameter logic [PAY_W-1:0] DEV_PAY = 7'h11
) (
  input  logic              sel_dev,
  output logic [BYTE_W-1:0] id_byte
);
  logic [BYTE_W-1:0] mfr_byte;
  logic [BYTE_W-1:0] dev_byte;

  always_comb begin
    mfr_byte = odd_byte(MFR_PAY);
    dev_byte = odd_byte(DEV_PAY);
    id_byte  = sel_dev ? dev_byte : mfr_byte;
  end
endmodule

// File: rtl/prom_array.sv
module prom_array
  import prom_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [BYTE_W-1:0] mem_d [DEPTH];
  logic [BYTE_W-1:0] old_word;

  assign old_word = mem_q[addr];
  assign rd_data  = old_word;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem_d[i] = '1;
    end else if (wr_en) begin
      mem_d[addr] = old_word & wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase || wr_en) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (mem_q[0] == '1) && (mem_q[DEPTH-1] == '1)); // R2

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> ((mem_q[$past(addr)] & ~$past(old_word)) == '0)); // R3
endmodule

// File: rtl/prom_port.sv
module prom_port
  import prom_port_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [PAY_W-1:0]  MFR_PAY = 7'h01,
  parameter logic [PAY_W-1:0]  DEV_PAY = 7'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              hv_id,
  input  logic [ADDR_W-1:0] addr,
  input  logic              prog_en,
  input  logic [7:0]        prog_data,
  input  logic              erase_all,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  output logic              pwr_standby,
  output logic              id_bad
);
  logic              srst_n;
  logic [BYTE_W-1:0] arr_byte;
  logic [BYTE_W-1:0] id_byte;

  src_e              src_d;
  logic [BYTE_W-1:0] dq_d, dq_q;
  logic              oe_d, oe_q;
  logic              stby_d, stby_q;
  logic              bad_d, bad_q;
  logic              idm_d, idm_q;
  logic              upper_hi;

  prom_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  prom_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .rst_n   (srst_n),
    .erase   (erase_all),
    .wr_en   (prog_en),
    .addr    (addr),
    .wr_data (prog_data),
    .rd_data (arr_byte)
  );

  prom_id_gen #(.MFR_PAY(MFR_PAY), .DEV_PAY(DEV_PAY)) u_id (
    .sel_dev (addr[0]),
    .id_byte (id_byte)
  );

  generate
    if (ADDR_W > 1) begin : g_upper
      assign upper_hi = |addr[ADDR_W-1:1];
    end else begin : g_no_upper
      assign upper_hi = 1'b0;
    end
  endgenerate

  always_comb begin
    if (ce_n || oe_n) src_d = SRC_NONE;
    else if (hv_id)   src_d = SRC_ID;
    else              src_d = SRC_ARRAY;

    case (src_d)
      SRC_ARRAY: dq_d = arr_byte;
      SRC_ID:    dq_d = id_byte;
      default:   dq_d = '0;
    endcase

    oe_d   = (src_d != SRC_NONE);
    idm_d  = (src_d == SRC_ID);
    stby_d = ce_n;
    bad_d  = hv_id && !ce_n && upper_hi;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dq_q   <= '0;
      oe_q   <= 1'b0;
      stby_q <= 1'b1;
      bad_q  <= 1'b0;
      idm_q  <= 1'b0;
    end else begin
      dq_q   <= dq_d;
      oe_q   <= oe_d;
      stby_q <= stby_d;
      bad_q  <= bad_d;
      idm_q  <= idm_d;
    end
  end

  assign dq_o        = dq_q;
  assign dq_oe       = oe_q;
  assign pwr_standby = stby_q;
  assign id_bad      = bad_q;

  AST_DRIVE_NOT_STANDBY: assert property (@(posedge clk) disable iff (!srst_n)
    dq_oe |-> !pwr_standby); // R5

  AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    !dq_oe |-> (dq_o == '0)); // R4

  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!srst_n)
    (dq_oe && idm_q) |-> (^dq_o)); // R8

  AST_BAD_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!srst_n)
    id_bad |-> !pwr_standby); // R9
endmodule

// File: tb/prom_port_tb.sv
`timescale 1ns/1ps
module prom_port_tb;
  localparam int ADDR_W = 8;
  localparam logic [6:0] MFR = 7'h01;
  localparam logic [6:0] DEV = 7'h11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n, oe_n, hv_id, prog_en, erase_all;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        prog_data;
  logic [7:0]        dq_o;
  logic              dq_oe, pwr_standby, id_bad;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  prom_port #(.ADDR_W(ADDR_W), .MFR_PAY(MFR), .DEV_PAY(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .hv_id(hv_id),
    .addr(addr), .prog_en(prog_en), .prog_data(prog_data),
    .erase_all(erase_all), .dq_o(dq_o), .dq_oe(dq_oe),
    .pwr_standby(pwr_standby), .id_bad(id_bad)
  );

  function automatic logic [7:0] exp_id(input logic [6:0] p);
    return {~(^p), p};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; prog_data = d; prog_en = 1'b1;
    step();
    prog_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] v);
    ce_n = 1'b0; oe_n = 1'b0; hv_id = 1'b0; addr = a;
    step();
    v = dq_o;
    ce_n = 1'b1; oe_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 standby", {7'd0, pwr_standby}, 8'd1);
    check("R1 dq_oe", {7'd0, dq_oe}, 8'd0);
    check("R1 dq_o", dq_o, 8'h00);
    check("R1 id_bad", {7'd0, id_bad}, 8'd0);
    rd(8'h05, v); check("R1 byte5", v, 8'hFF);
    rd(8'hFF, v); check("R1 top byte", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v;
    prog(8'h0A, 8'hF0);
    prog(8'h0A, 8'h3C);
    rd(8'h0A, v); check("R3 and-merge", v, 8'h30);
    prog(8'h0A, 8'hFF);
    rd(8'h0A, v); check("R3 no bit set", v, 8'h30);
  endtask

  task automatic t_read();
    logic [7:0] v;
    prog(8'h00, 8'h00);
    prog(8'hFF, 8'hA5);
    prog(8'h33, 8'h5A);
    rd(8'h00, v); check("R7 addr0", v, 8'h00);
    rd(8'hFF, v); check("R7 addr top", v, 8'hA5);
    rd(8'h33, v); check("R7 addr33", v, 8'h5A);
    ce_n = 1'b0; oe_n = 1'b0; addr = 8'hFF;
    step();
    check("R4 dq_oe driven", {7'd0, dq_oe}, 8'd1);
    addr = 8'h33;
    step();
    check("R7 back-to-back", dq_o, 8'h5A);
    ce_n = 1'b1; oe_n = 1'b1;
    step();
    check("R4 release", {7'd0, dq_oe}, 8'd0);
    check("R4 quiet zero", dq_o, 8'h00);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    erase_all = 1'b1; step(); erase_all = 1'b0;
    rd(8'h33, v); check("R2 erased 33", v, 8'hFF);
    rd(8'h0A, v); check("R2 erased 0A", v, 8'hFF);
  endtask

  task automatic t_standby();
    ce_n = 1'b1; oe_n = 1'b0; hv_id = 1'b0; addr = 8'h00;
    step();
    check("R5 oe low stby", {7'd0, pwr_standby}, 8'd1);
    check("R5 oe low no drive", {7'd0, dq_oe}, 8'd0);
    check("R5 bus zero", dq_o, 8'h00);
    hv_id = 1'b1; addr = 8'h82;
    step();
    check("R5 hv no drive", {7'd0, dq_oe}, 8'd0);
    check("R9 no bad in standby", {7'd0, id_bad}, 8'd0);
    hv_id = 1'b0; oe_n = 1'b1;
    step();
  endtask

  task automatic t_oe_gate();
    ce_n = 1'b0; oe_n = 1'b1; addr = 8'h10;
    step();
    check("R6 active", {7'd0, pwr_standby}, 8'd0);
    check("R6 no drive", {7'd0, dq_oe}, 8'd0);
    check("R6 bus zero", dq_o, 8'h00);
    ce_n = 1'b1;
    step();
  endtask

  task automatic t_id();
    ce_n = 1'b0; oe_n = 1'b0; hv_id = 1'b1; addr = 8'h00;
    step();
    check("R8 mfr byte", dq_o, exp_id(MFR));
    check("R8 driven", {7'd0, dq_oe}, 8'd1);
    check("R9 clean addr", {7'd0, id_bad}, 8'd0);
    addr = 8'h01;
    step();
    check("R8 dev byte", dq_o, exp_id(DEV));
    addr = 8'h81;
    step();
    check("R9 bad high", {7'd0, id_bad}, 8'd1);
    check("R9 dev still", dq_o, exp_id(DEV));
    addr = 8'h02;
    step();
    check("R9 bad low bit", {7'd0, id_bad}, 8'd1);
    check("R9 mfr still", dq_o, exp_id(MFR));
    hv_id = 1'b0; addr = 8'h82;
    step();
    check("R9 cleared", {7'd0, id_bad}, 8'd0);
    ce_n = 1'b1; oe_n = 1'b1;
    step();
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; hv_id = 1'b0;
    prog_en = 1'b0; erase_all = 1'b0; addr = '0; prog_data = '0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_program();
    t_read();
    t_erase();
    t_standby();
    t_oe_gate();
    t_id();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule